// File: doc/BRIEF.md
# Ratio-Based Power-Good Window Monitor

This block watches a switched supply rail and raises an active-low, open-drain power-good signal once the rail has settled. It receives digitised input and output voltage codes, each pair qualified by a one-cycle sample strobe, and an enable for the channel. The output-to-input ratio is tested against two thresholds, an upper and a lower one, so the indication has hysteresis. Both tests use cross-multiplication, so the block needs no divider.

Assertion is deliberate and release is fast. A sample above the upper threshold starts a qualification delay that is set in clock cycles. The line is pulled low only if every condition holds for the whole delay. A sample below the lower threshold, an input below the undervoltage level, or a disabled channel releases the line. An open-drain line is never driven high: when released it is left to an external pull-up.

Top module: `pgood_window_mon`

## Requirements
- R1: After synchronous reset the line is released, and the stored comparison results read as not-above-upper, not-below-lower and input-under-limit.
- R2: A sample counts as above the upper threshold only when vout*100 > vin*UP_PCT (default 90). Equality does not count.
- R3: While asserted, a sample with vout*100 < vin*DN_PCT (default 85) releases the line at the clock edge after the sample edge. A sample exactly at the threshold keeps the line asserted.
- R4: If a qualifying sample is taken at edge e, and enable and the input level stay valid, the line is pulled low after edge e+1+DLY_CYC and not before.
- R5: A sample that is not above the upper threshold during the delay cancels the pending assertion. A later qualifying sample starts the full delay again.
- R6: While asserted, samples that fall between the two thresholds keep the line asserted.
- R7: Driving enable low releases the line in the same cycle, with no clock edge needed. Raising enable again with qualifying stored results restarts the full delay.
- R8: A sample whose input code is below UVLO_CODE (default 1720) releases the line at the next edge and blocks assertion, whatever the ratio.
- R9: The power-good pin is driven only to logic 0. When released it is high impedance and reads high through an external pull-up.
- R10: Voltage codes presented while the sample strobe is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable, active high |
| smp_vld | input | 1 | Qualifies vin_code and vout_code for one cycle |
| vin_code | input | VW | Unsigned input-voltage code |
| vout_code | input | VW | Unsigned output-voltage code |
| pgood_n | output | 1 | Open-drain power-good, low when good, high impedance otherwise |

## Verification
The hardest case to reach is a disturbance that lands partway through the qualification window. The counter must then discard its progress, without counting on or asserting early. The bench places an in-band sample several cycles after a qualifying one and checks that a fresh qualifying sample again needs the full delay. It also drops enable while the line is asserted and then restores it without a new sample, so that the stored results alone have to carry a complete new delay. A cycle-by-cycle reference model built on a qualification streak counter checks the pin at every clock.

// File: rtl/pgw_pkg.sv
// Shared types for the power-good window monitor.
package pgw_pkg;
    // Qualification state of the power-good sequencer.
    typedef enum logic [1:0] {
        PG_OFF  = 2'd0,
        PG_WAIT = 2'd1,
        PG_GOOD = 2'd2
    } pg_state_e;
endpackage

// File: rtl/pgw_ratio_cmp.sv
// Ratio comparator: on each strobed sample, registers whether vout/vin
// lies above the upper percentage, below the lower percentage, and
// whether vin clears the undervoltage code. Uses cross-multiplication.
// Assumes DN_PCT < UP_PCT <= 100 and unsigned codes.
module pgw_ratio_cmp #(
    parameter int unsigned VW        = 12,
    parameter int unsigned UP_PCT    = 90,
    parameter int unsigned DN_PCT    = 85,
    parameter int unsigned UVLO_CODE = 1720
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [VW-1:0] vin_code,
    input  logic [VW-1:0] vout_code,
    output logic          hi_ok,
    output logic          lo_bad,
    output logic          uv_ok
);
    localparam int unsigned MW = VW + 8;

    logic [MW-1:0] vout_scaled;
    logic [MW-1:0] vin_up;
    logic [MW-1:0] vin_dn;

    // Scale both codes so the percentage tests need no division.
    always_comb begin
        vout_scaled = MW'(vout_code) * MW'(100);
        vin_up      = MW'(vin_code) * MW'(UP_PCT);
        vin_dn      = MW'(vin_code) * MW'(DN_PCT);
    end

    // Capture the comparison results only on strobed samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_ok  <= 1'b0;
            lo_bad <= 1'b0;
            uv_ok  <= 1'b0;
        end else if (smp_vld) begin
            hi_ok  <= vout_scaled > vin_up;
            lo_bad <= vout_scaled < vin_dn;
            uv_ok  <= vin_code >= VW'(UVLO_CODE);
        end
    end
endmodule

// File: rtl/pgw_delay_cnt.sv
// Qualification delay counter: clears on request, counts while told to,
// and flags the last cycle of a DLY_CYC-long window. Assumes DLY_CYC >= 1.
module pgw_delay_cnt #(
    parameter int unsigned DLY_CYC = 4000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int unsigned CW = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

    logic [CW-1:0] cnt;

    // Count elapsed qualification cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc && cnt != LAST) cnt <= cnt + 1'b1;
    end

    // Window complete on the final count value.
    always_comb done = (cnt == LAST);
endmodule

// File: rtl/pgw_ctrl.sv
// Sequencer: OFF until a qualifying sample, WAIT for the delay while
// qualification holds, GOOD until a low sample, undervoltage or disable.
// Assumes comparator outputs are registered and stable between samples.
module pgw_ctrl
    import pgw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hi_ok,
    input  logic lo_bad,
    input  logic uv_ok,
    input  logic dly_done,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic good
);
    pg_state_e state, state_nx;
    logic      qual;

    // Conditions required to keep qualifying.
    always_comb qual = en && uv_ok && hi_ok;

    // Next-state and counter control.
    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (state)
            PG_OFF: begin
                cnt_clr = 1'b1;
                if (qual) state_nx = PG_WAIT;
            end
            PG_WAIT: begin
                if (!qual) begin
                    state_nx = PG_OFF;
                    cnt_clr  = 1'b1;
                end else if (dly_done) begin
                    state_nx = PG_GOOD;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            PG_GOOD: begin
                cnt_clr = 1'b1;
                if (!en || !uv_ok || lo_bad) state_nx = PG_OFF;
            end
            default: state_nx = PG_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PG_OFF;
        else        state <= state_nx;
    end

    // Good while in the final state.
    always_comb good = (state == PG_GOOD);
endmodule

// File: rtl/pgood_window_mon.sv
// Power-good window monitor top: ratio comparator, delay counter and
// sequencer, with the open-drain pin gated directly by enable so that
// disabling releases the line without waiting for a clock edge.
// Assumes an external pull-up on pgood_n.
module pgood_window_mon #(
    parameter int unsigned VW        = 12,
    parameter int unsigned UP_PCT    = 90,
    parameter int unsigned DN_PCT    = 85,
    parameter int unsigned UVLO_CODE = 1720,
    parameter int unsigned DLY_CYC   = 4000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          smp_vld,
    input  logic [VW-1:0] vin_code,
    input  logic [VW-1:0] vout_code,
    output wire           pgood_n
);
    logic hi_ok, lo_bad, uv_ok;
    logic cnt_clr, cnt_inc, dly_done;
    logic good, drive_low;

    pgw_ratio_cmp #(
        .VW(VW), .UP_PCT(UP_PCT), .DN_PCT(DN_PCT), .UVLO_CODE(UVLO_CODE)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .vin_code(vin_code), .vout_code(vout_code),
        .hi_ok(hi_ok), .lo_bad(lo_bad), .uv_ok(uv_ok)
    );

    pgw_delay_cnt #(.DLY_CYC(DLY_CYC)) u_dly (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .done(dly_done)
    );

    pgw_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en),
        .hi_ok(hi_ok), .lo_bad(lo_bad), .uv_ok(uv_ok), .dly_done(dly_done),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .good(good)
    );

    // Enable gates the pull-down combinationally.
    always_comb drive_low = good && en;

    // Open-drain pin: pull low or float.
    assign pgood_n = drive_low ? 1'b0 : 1'bz;
endmodule

// File: rtl/pgw_checker.sv
// Property checker for the power-good window monitor, bound to the top.
// Tracks the qualification streak with its own saturating counter.
module pgw_checker #(
    parameter int unsigned DLY_CYC = 4000000
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic hi_ok,
    input logic lo_bad,
    input logic uv_ok,
    input logic drive_low
);
    localparam int unsigned RW = $clog2(DLY_CYC + 2);
    localparam logic [RW-1:0] RMAX = RW'(DLY_CYC + 1);

    logic [RW-1:0] run;

    // Consecutive edges with all qualifying conditions present.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= '0;
        else if (en && uv_ok && hi_ok) run <= (run == RMAX) ? run : run + 1'b1;
        else run <= '0;
    end

    assert_delay_met_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> run >= RW'(DLY_CYC));

    assert_low_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_bad |=> !drive_low);

    assert_uvlo_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_ok |=> !drive_low);

    assert_band_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low && en && uv_ok && !lo_bad) |=> (drive_low || !en));

    assert_no_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_ok && !drive_low) |=> !drive_low);
endmodule

bind pgood_window_mon pgw_checker #(.DLY_CYC(DLY_CYC)) u_pgw_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .hi_ok(hi_ok), .lo_bad(lo_bad),
    .uv_ok(uv_ok), .drive_low(drive_low)
);

// File: tb/pgood_window_mon_tb.sv
module pgood_window_mon_tb;
    localparam int VW  = 12;
    localparam int DLY = 20;
    localparam int UVL = 1720;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic smp_vld = 1'b0;
    logic [VW-1:0] vin_code = '0;
    logic [VW-1:0] vout_code = '0;
    wire pgood_n;

    pullup (pgood_n);

    pgood_window_mon #(.VW(VW), .UP_PCT(90), .DN_PCT(85), .UVLO_CODE(UVL), .DLY_CYC(DLY))
    u_dut (.clk(clk), .rst_n(rst_n), .en(en), .smp_vld(smp_vld),
           .vin_code(vin_code), .vout_code(vout_code), .pgood_n(pgood_n));

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // Reference model: sampled flags plus a qualification streak.
    bit m_hi, m_lo, m_uv, m_good;
    int streak;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_uv = 0; m_good = 0; streak = 0;
        end else begin
            if (en && m_uv && m_hi) streak = streak + 1; else streak = 0;
            if (m_good) begin
                if (!en || !m_uv || m_lo) m_good = 0;
            end else if (streak >= DLY + 1) m_good = 1;
            if (smp_vld) begin
                m_hi = (int'(vout_code) * 100) > (int'(vin_code) * 90);
                m_lo = (int'(vout_code) * 100) < (int'(vin_code) * 85);
                m_uv = int'(vin_code) >= UVL;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pgood_n=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (released line reads 1, R9).
    always @(negedge clk) begin
        if (rst_n) check({cur_req, "/R9"}, pgood_n, !(m_good && en));
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic sample(input int vi, input int vo);
        @(posedge clk); #1;
        vin_code = VW'(vi); vout_code = VW'(vo); smp_vld = 1'b1;
        @(posedge clk); #1;
        smp_vld = 1'b0;
    endtask

    task automatic edges_to_low(output int n);
        n = 0;
        while (pgood_n !== 1'b0 && n < 200) begin @(posedge clk); #1; n++; end
    endtask

    bit done = 0;
    initial begin
        #(10 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        cur_req = "R1"; check("R1 reset released", pgood_n, 1'b1);

        // R10: qualifying codes without strobe are ignored.
        cur_req = "R10"; en = 1'b1;
        vin_code = 12'd3000; vout_code = 12'd3000;
        tick(40);
        check("R10 no strobe no assert", pgood_n, 1'b1);

        // R2: exactly 90% does not qualify.
        cur_req = "R2"; sample(3000, 2700); tick(40);
        check("R2 equal upper ignored", pgood_n, 1'b1);

        // R4: just above 90%, measure latency.
        cur_req = "R4"; sample(3000, 2701); edges_to_low(n);
        checks++;
        if (n != DLY + 1) begin fails++; $display("FAIL R4 latency=%0d expected=%0d", n, DLY + 1); end

        // R6: in-band samples hold; lower boundary holds.
        cur_req = "R6"; sample(3000, 2600); tick(30);
        check("R6 in band hold", pgood_n, 1'b0);
        sample(3000, 2550); tick(5);
        check("R3 equal lower holds", pgood_n, 1'b0);

        // R3: below 85% releases one edge after the sample edge.
        cur_req = "R3"; sample(3000, 2549);
        check("R3 not yet released", pgood_n, 1'b0);
        tick(1);
        check("R3 released", pgood_n, 1'b1);

        // R5: abort during delay, then full restart.
        cur_req = "R5"; sample(3000, 2800); tick(8);
        sample(3000, 2600); tick(40);
        check("R5 aborted no assert", pgood_n, 1'b1);
        sample(3000, 2800); edges_to_low(n);
        checks++;
        if (n != DLY + 1) begin fails++; $display("FAIL R5 restart latency=%0d expected=%0d", n, DLY + 1); end

        // R7: disable releases immediately; re-enable restarts the delay.
        cur_req = "R7"; tick(3);
        @(posedge clk); #2; en = 1'b0; #1;
        check("R7 immediate release", pgood_n, 1'b1);
        @(posedge clk); #1; tick(3);
        en = 1'b1;
        edges_to_low(n);
        checks++;
        if (n != DLY + 1) begin fails++; $display("FAIL R7 reenable latency=%0d expected=%0d", n, DLY + 1); end

        // R8: undervoltage releases and blocks.
        cur_req = "R8"; sample(1700, 1700);
        tick(1);
        check("R8 uvlo release", pgood_n, 1'b1);
        sample(1000, 1000); tick(40);
        check("R8 uvlo blocks", pgood_n, 1'b1);
        sample(1720, 1720); edges_to_low(n);
        checks++;
        if (n != DLY + 1) begin fails++; $display("FAIL R8 at limit latency=%0d expected=%0d", n, DLY + 1); end

        tick(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule